// File: doc/BRIEF.md
# Binary-Tree Piecewise-Affine Evaluator

This block evaluates a piecewise-affine function of an N-component input vector. Each component is a signed fixed-point value in the range [-1, 1). The function is described by a binary decision tree held in an internal word memory. Every internal node carries one hyperplane. The sign of that hyperplane at the input point picks the subtree to descend into. Every leaf names one region and points at that region's affine coefficients: a gain row and an offset for each of the M outputs.

A sequencer walks the tree one node at a time. A single multiply-accumulate datapath is reused for two jobs: the hyperplane tests during the walk, and the final affine evaluation of every output.

The tree and its coefficients are written beforehand through a simple load port. A request is raised on `start_i` while `ready_o` is high. The input vector is captured at that moment. `done_o` pulses once all M outputs are valid. An optional pad of idle cycles stretches the latency so that it can be aligned with a fixed sampling period.

Top module: `pwa_tree_eval`

## Requirements
- R1: After reset `done_o` is 0, `ready_o` is 1 and every output field of `y_o` is 0.
- R2: A word with bit 2·AW set is a leaf; otherwise it is an internal node. An internal node's word holds the left-child address in bits [AW-1:0] and the right-child address in bits [2·AW-1:AW]. The N gains a_i follow at the node address plus 1+i, and the offset c follows at the node address plus 1+N. The walk starts at address 0. With S = Σ a_i·x_i + c·2^(B-1), the walk continues at the right child when S ≥ 0 and at the left child when S < 0.
- R3: In a leaf word, bits [AW-1:0] give a base address. Output k uses gains at base+k·(N+1)+i and its offset at base+k·(N+1)+N. The output value is floor((Σ g_i·x_i + h·2^(B-1)) / 2^(B-1)), held as a YW-bit two's-complement value in `y_o[k*YW +: YW]`. All stored coefficients are B-bit two's complement.
- R4: If a request is accepted in cycle c, `done_o` is high in cycle c + d·(N+2) + M·(N+2) + 3 + PAD. Here d is the number of internal nodes the walk passes through.
- R5: `done_o` is high for exactly one cycle. `ready_o` is high when idle, including the cycle of `done_o`, and low from the cycle after acceptance until completion.
- R6: `start_i` raised while `ready_o` is low is ignored. The running evaluation keeps the input vector captured at acceptance, and its latency and results are unchanged.
- R7: `y_o` holds its values from the `done_o` cycle until the next accepted request.
- R8: When `ld_we_i` is high at a rising clock edge, `ld_data_i` is written to the word at `ld_addr_i`. Component i of the input is taken from `x_i[i*B +: B]`, in two's complement with B-1 fraction bits.
- R9: A hyperplane sum of exactly zero selects the right child. A sum of -1 LSB of the offset scale selects the left child.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Evaluation request, accepted while `ready_o` is high |
| x_i | input | N·B | Packed input vector, component i at [i*B +: B] |
| ready_o | output | 1 | Idle and able to accept a request |
| ld_we_i | input | 1 | Memory write enable |
| ld_addr_i | input | AW | Memory write address |
| ld_data_i | input | WW | Memory write word |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | M·YW | Packed outputs, output k at [k*YW +: YW] |

## Verification
A wrong branch decision or a corrupted node pointer sends the walk to another leaf. This shows at the very next `done_o` in two ways: the output values belong to a different region, and the latency changes by a multiple of N+2 whenever the reached leaf has a different depth. A sequencer counter that is off by one shifts every coefficient address. It appears as wrong outputs, or as a latency outside the allowed set, on the first evaluation after loading. A request that leaks in while busy is caught by comparing that run's results and latency with those expected for the first captured input.

// File: rtl/pwa_tree_pkg.sv
package pwa_tree_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_EMAC,
    ST_EOFS,
    ST_OMAC,
    ST_OOFS,
    ST_OST,
    ST_PAD,
    ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    MAC_HOLD,
    MAC_CLR,
    MAC_MUL,
    MAC_OFS
  } mac_op_t;

endpackage

// File: rtl/pwa_word_mem.sv
module pwa_word_mem #(
  parameter int AW = 7,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  localparam int DEPTH = 2 ** AW;

  logic [WW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

  // R8
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/pwa_mac.sv
module pwa_mac
  import pwa_tree_pkg::*;
#(
  parameter int B    = 16,
  parameter int YW   = 19,
  parameter int ACCW = 35
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mac_op_t             op,
  input  logic signed [B-1:0] coef,
  input  logic signed [B-1:0] xin,
  output logic                neg_o,
  output logic [YW-1:0]       res_o
);

  logic signed [2*B-1:0]  prod;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] ofs_ext;
  logic signed [ACCW-1:0] sum;
  logic signed [ACCW-1:0] acc_d, acc_q;

  assign prod     = coef * xin;
  assign prod_ext = ACCW'(prod);
  assign ofs_ext  = ACCW'(coef) <<< (B - 1);
  assign sum      = acc_q + ofs_ext;

  always_comb begin
    acc_d = acc_q;
    case (op)
      MAC_CLR: acc_d = '0;
      MAC_MUL: acc_d = acc_q + prod_ext;
      MAC_OFS: acc_d = sum;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign neg_o = sum[ACCW-1];
  assign res_o = acc_q[B-1 +: YW];

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MAC_HOLD) |=> $stable(acc_q));

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MAC_CLR) |=> (acc_q == '0));

endmodule

// File: rtl/pwa_seq.sv
module pwa_seq
  import pwa_tree_pkg::*;
#(
  parameter int N   = 2,
  parameter int M   = 2,
  parameter int AW  = 7,
  parameter int PAD = 0,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int KW = (M > 1) ? $clog2(M) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2*AW:0]   hdr,
  input  logic            neg_i,
  output logic [AW-1:0]   raddr,
  output mac_op_t         mac_op,
  output logic [IW-1:0]   xsel,
  output logic [KW-1:0]   ysel,
  output logic            ystore,
  output logic            ready_o,
  output logic            done_o
);

  localparam int PW   = $clog2(PAD + 2);
  localparam int BASE = 3 + PAD + M * (N + 2);

  seq_state_t    state_d, state_q;
  logic [AW-1:0] ptr_d, ptr_q, cp_d, cp_q, left_d, left_q, right_d, right_q;
  logic [IW-1:0] i_d, i_q;
  logic [KW-1:0] k_d, k_q;
  logic [PW-1:0] pad_d, pad_q;
  logic          done_d, done_q;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cp_d    = cp_q;
    left_d  = left_q;
    right_d = right_q;
    i_d     = i_q;
    k_d     = k_q;
    pad_d   = pad_q;
    mac_op  = MAC_HOLD;
    ystore  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_HDR;
          ptr_d   = '0;
        end
      end
      ST_HDR: begin
        mac_op = MAC_CLR;
        i_d    = '0;
        if (hdr[2*AW]) begin
          cp_d    = hdr[AW-1:0];
          k_d     = '0;
          state_d = ST_OMAC;
        end else begin
          left_d  = hdr[AW-1:0];
          right_d = hdr[2*AW-1:AW];
          cp_d    = ptr_q + AW'(1);
          state_d = ST_EMAC;
        end
      end
      ST_EMAC, ST_OMAC: begin
        mac_op = MAC_MUL;
        cp_d   = cp_q + AW'(1);
        if (i_q == IW'(N - 1)) begin
          i_d     = '0;
          state_d = (state_q == ST_EMAC) ? ST_EOFS : ST_OOFS;
        end else begin
          i_d = i_q + IW'(1);
        end
      end
      ST_EOFS: begin
        ptr_d   = neg_i ? left_q : right_q;
        state_d = ST_HDR;
      end
      ST_OOFS: begin
        mac_op  = MAC_OFS;
        cp_d    = cp_q + AW'(1);
        state_d = ST_OST;
      end
      ST_OST: begin
        ystore = 1'b1;
        mac_op = MAC_CLR;
        if (k_q == KW'(M - 1)) begin
          k_d   = '0;
          pad_d = '0;
          if (PAD > 0) state_d = ST_PAD;
          else         state_d = ST_FIN;
        end else begin
          k_d     = k_q + KW'(1);
          state_d = ST_OMAC;
        end
      end
      ST_PAD: begin
        pad_d = pad_q + PW'(1);
        if (pad_q == PW'(PAD - 1)) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign done_d = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cp_q    <= '0;
      left_q  <= '0;
      right_q <= '0;
      i_q     <= '0;
      k_q     <= '0;
      pad_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cp_q    <= cp_d;
      left_q  <= left_d;
      right_q <= right_d;
      i_q     <= i_d;
      k_q     <= k_d;
      pad_q   <= pad_d;
      done_q  <= done_d;
    end
  end

  assign raddr   = (state_q == ST_HDR) ? ptr_q : cp_q;
  assign xsel    = i_q;
  assign ysel    = k_q;
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;

  // Cycle counter kept for the latency check only.
  logic [15:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lat_q <= '0;
    else if (ready_o && start_i)    lat_q <= 16'd1;
    else if (state_q != ST_IDLE)    lat_q <= lat_q + 16'd1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ready_o && state_q != ST_FIN) |=> !ready_o);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((int'(lat_q) >= BASE) && (((int'(lat_q) - BASE) % (N + 2)) == 0)));

endmodule

// File: rtl/pwa_tree_eval.sv
module pwa_tree_eval
  import pwa_tree_pkg::*;
#(
  parameter int N_IN  = 2,
  parameter int M_OUT = 2,
  parameter int B     = 16,
  parameter int AW    = 7,
  parameter int PAD   = 0,
  localparam int WW   = (B > 2 * AW + 1) ? B : 2 * AW + 1,
  localparam int GW   = $clog2(N_IN + 1) + 1,
  localparam int YW   = B + GW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [N_IN*B-1:0]     x_i,
  output logic                  ready_o,
  input  logic                  ld_we_i,
  input  logic [AW-1:0]         ld_addr_i,
  input  logic [WW-1:0]         ld_data_i,
  output logic                  done_o,
  output logic [M_OUT*YW-1:0]   y_o
);

  localparam int ACCW = 2 * B + GW;
  localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int KW   = (M_OUT > 1) ? $clog2(M_OUT) : 1;

  logic [AW-1:0]       raddr;
  logic [WW-1:0]       rdata;
  mac_op_t             mac_op;
  logic [IW-1:0]       xsel;
  logic [KW-1:0]       ysel;
  logic                ystore;
  logic                neg;
  logic [YW-1:0]       res;
  logic                accept;
  logic signed [B-1:0] x_q [N_IN];
  logic [YW-1:0]       y_q [M_OUT];

  assign accept = start_i && ready_o;

  pwa_word_mem #(.AW(AW), .WW(WW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ld_we_i),
    .waddr (ld_addr_i),
    .wdata (ld_data_i),
    .raddr (raddr),
    .rdata (rdata)
  );

  pwa_seq #(.N(N_IN), .M(M_OUT), .AW(AW), .PAD(PAD)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .hdr     (rdata[2*AW:0]),
    .neg_i   (neg),
    .raddr   (raddr),
    .mac_op  (mac_op),
    .xsel    (xsel),
    .ysel    (ysel),
    .ystore  (ystore),
    .ready_o (ready_o),
    .done_o  (done_o)
  );

  pwa_mac #(.B(B), .YW(YW), .ACCW(ACCW)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (mac_op),
    .coef  (rdata[B-1:0]),
    .xin   (x_q[xsel]),
    .neg_o (neg),
    .res_o (res)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_xin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      x_q[g] <= '0;
      else if (accept) x_q[g] <= x_i[g*B +: B];
    end
  end

  for (genvar g = 0; g < M_OUT; g++) begin : g_yout
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  y_q[g] <= '0;
      else if (ystore && (ysel == KW'(g)))         y_q[g] <= res;
    end
    assign y_o[g*YW +: YW] = y_q[g];
  end

  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> $stable(y_o));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (ready_o && !done_o));

endmodule

// File: tb/test_pwa_tree_eval.sv
module test_pwa_tree_eval;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int M  = 2;
  localparam int B  = 16;
  localparam int AW = 7;
  localparam int WW = 16;
  localparam int YW = 19;
  localparam int DEPTH = 128;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [N*B-1:0]    x_i;
  logic              ready_o;
  logic              ld_we_i;
  logic [AW-1:0]     ld_addr_i;
  logic [WW-1:0]     ld_data_i;
  logic              done_o;
  logic [M*YW-1:0]   y_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] tm [DEPTH];
  int nf;
  int q_addr [64];
  int q_dep  [64];
  int q_head, q_tail;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwa_tree_eval #(.N_IN(N), .M_OUT(M), .B(B), .AW(AW), .PAD(0)) i_pwa_tree_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .x_i       (x_i),
    .ready_o   (ready_o),
    .ld_we_i   (ld_we_i),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .done_o    (done_o),
    .y_o       (y_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // Expected result from the stated tree format and arithmetic (R2, R3, R9)
  task automatic model(input logic [15:0] x0, input logic [15:0] x1,
                       output int dep, output logic [YW-1:0] e0, output logic [YW-1:0] e1);
    int p;
    int bs;
    longint s;
    logic [15:0] h;
    p = 0;
    dep = 0;
    h = tm[0];
    for (int g = 0; g < 40; g++) begin
      h = tm[p];
      if (h[14]) break;
      s = sx(tm[p+1]) * sx(x0) + sx(tm[p+2]) * sx(x1) + (sx(tm[p+3]) <<< 15);
      p = (s < 0) ? int'(h[6:0]) : int'(h[13:7]);
      dep++;
    end
    bs = int'(h[6:0]);
    s = sx(tm[bs]) * sx(x0) + sx(tm[bs+1]) * sx(x1) + (sx(tm[bs+2]) <<< 15);
    e0 = YW'(s >>> 15);
    s = sx(tm[bs+3]) * sx(x0) + sx(tm[bs+4]) * sx(x1) + (sx(tm[bs+5]) <<< 15);
    e1 = YW'(s >>> 15);
  endtask

  task automatic load_mem();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_we_i   = 1'b1;
      ld_addr_i = AW'(a);
      ld_data_i = tm[a];
    end
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic place(input int dep, input int maxd, output int a);
    a = nf;
    if (dep < maxd && (dep == 0 || $urandom_range(3) != 0)) begin
      nf += N + 2;
      q_addr[q_tail] = a;
      q_dep[q_tail]  = dep;
      q_tail++;
    end else begin
      tm[a] = 16'(32'h4000 | (a + 1));
      for (int j = 1; j <= M * (N + 1); j++) tm[a+j] = 16'($urandom);
      nf += 1 + M * (N + 1);
    end
  endtask

  task automatic build_tree(input int maxd);
    int root, l, r, a, dd;
    for (int j = 0; j < DEPTH; j++) tm[j] = 16'($urandom) & 16'h3FFF;
    nf = 0; q_head = 0; q_tail = 0;
    place(0, maxd, root);
    while (q_head < q_tail) begin
      a  = q_addr[q_head];
      dd = q_dep[q_head];
      q_head++;
      place(dd + 1, maxd, l);
      place(dd + 1, maxd, r);
      tm[a] = 16'((r << 7) | l);
      for (int j = 1; j <= N + 1; j++) tm[a+j] = 16'($urandom);
    end
  endtask

  // Root internal node with given hyperplane, two leaves.
  task automatic build_split(input logic [15:0] a0, input logic [15:0] a1, input logic [15:0] c);
    for (int j = 0; j < DEPTH; j++) tm[j] = 16'h0000;
    tm[0] = 16'((11 << 7) | 4);
    tm[1] = a0; tm[2] = a1; tm[3] = c;
    tm[4]  = 16'h4005;                       // left leaf, base 5
    for (int j = 5; j < 11; j++) tm[j] = 16'h1000;
    tm[11] = 16'h400C;                       // right leaf, base 12
    for (int j = 12; j < 18; j++) tm[j] = 16'hE000;
  endtask

  task automatic run_eval(input logic [15:0] x0, input logic [15:0] x1,
                          input bit inject, input string tag);
    int dep, cnt, lat;
    logic [YW-1:0] e0, e1, y0s, y1s;
    model(x0, x1, dep, e0, e1);
    lat = dep * (N + 2) + M * (N + 2) + 3;
    @(negedge clk);
    x_i = {x1, x0};
    start_i = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start_i = 1'b0;
        chk(ready_o == 1'b0, "R5 ready low while busy", longint'(ready_o), 0);
      end
      if (inject && cnt == 2) begin
        start_i = 1'b1;
        x_i = ~{x1, x0};
      end
      if (inject && cnt == 3) start_i = 1'b0;
    end while (!done_o && cnt < 3000);
    chk(cnt == lat, inject ? "R6 latency with busy start" : "R4 latency", cnt, lat);
    chk(y_o[YW-1:0] == e0, {tag, " out0"}, longint'(y_o[YW-1:0]), longint'(e0));
    chk(y_o[2*YW-1:YW] == e1, {tag, " out1"}, longint'(y_o[2*YW-1:YW]), longint'(e1));
    chk(ready_o == 1'b1, "R5 ready with done", longint'(ready_o), 1);
    y0s = y_o[YW-1:0];
    y1s = y_o[2*YW-1:YW];
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done single cycle", longint'(done_o), 0);
    x_i = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk(y_o == {y1s, y0s}, "R7 outputs held", longint'(y_o), longint'({y1s, y0s}));
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    start_i = 1'b0;
    x_i = '0;
    ld_we_i = 1'b0;
    ld_addr_i = '0;
    ld_data_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", longint'(done_o), 0);
    chk(ready_o == 1'b1, "R1 ready after reset", longint'(ready_o), 1);
    chk(y_o == '0, "R1 outputs after reset", longint'(y_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: zero sum goes right, -1 LSB of offset scale goes left
    build_split(16'h0000, 16'h0000, 16'h0000);
    load_mem();
    run_eval(16'h1111, 16'h2222, 1'b0, "R9 zero sum right leaf");
    build_split(16'h0000, 16'h0000, 16'hFFFF);
    load_mem();
    run_eval(16'h1111, 16'h2222, 1'b0, "R9 negative sum left leaf");
    // 0.5 * (-1) + 0.5 = 0 exactly -> right
    build_split(16'h4000, 16'h0000, 16'h4000);
    load_mem();
    run_eval(16'h8000, 16'h7FFF, 1'b0, "R9 cancelling sum right leaf");

    // Leaf at the root: depth 0 (R3, R4), extreme inputs
    build_tree(0);
    load_mem();
    run_eval(16'h8000, 16'h8000, 1'b0, "R3 root leaf min inputs");
    run_eval(16'h7FFF, 16'h8000, 1'b0, "R3 root leaf mixed extremes");

    // R6: start during a busy walk is ignored
    build_tree(3);
    load_mem();
    run_eval(16'h0100, 16'hF300, 1'b1, "R6 busy start results");

    // Random trees and inputs (R2, R3, R8)
    for (int t = 0; t < 30; t++) begin
      build_tree(1 + (t % 3));
      load_mem();
      for (int v = 0; v < 3; v++)
        run_eval(16'($urandom), 16'($urandom), (v == 2), "R2 random walk");
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule